// File: doc/BRIEF.md
# Slip-Controlled Elastic Bit Buffer

This block is a single-bit elastic store placed between a write clock domain and a read clock domain. Serial bits enter on the write clock and leave on the read clock. The buffer absorbs phase wander and jitter between the two domains. A two-bit size code sets how much of the store is in use. The read side keeps the delay near half of the selected depth. It also watches the distance between the read pointer and the synchronised write pointer.

When the two pointers come within a guard distance of each other, the read side performs a controlled slip. If the writer is about to overtake unread data, half a depth of data is skipped. If the reader is about to catch up with the writer, half a depth of data is replayed. In both cases the read pointer lands half the selected depth behind the write pointer, and a sticky flag records which kind of slip happened.

A centring command, a change of size code, and the end of reset all re-centre the delay without raising any flag. The write pointer crosses into the read domain as Gray code through a chain of synchronising registers.

Top module: `slip_elastic_store`

## Requirements
- R1: The size code selects the active depth and the half depth. Code 2'b00 gives 256 bits, 2'b01 gives 128, 2'b10 gives 64 and 2'b11 gives 32. The half depth is always the depth divided by two.
- R2: While reset is held, rd_bit, slip_pos and slip_neg are 0. The first read-domain edge after reset re-centres the delay and raises no flag.
- R3: Both clocks may share one edge, with wr_en and rd_en high on every edge. In that case, once the delay is centred, the bit on rd_bit after an edge is the one written half+2 edges earlier. The extra 2 comes from the two synchroniser stages.
- R4: Suppose reads stop while writes continue, starting from a centred delay. Then the skip slip fires on the edge where the fill reaches depth minus GUARD (GUARD is 2 by default); that is pause edge number half-GUARD+1. slip_neg is set after that edge. The first bit read afterwards is the bit written 3+half edges before the slip edge's update, so data is skipped.
- R5: Suppose writes stop while reads continue, starting from a centred delay. Then the replay slip fires on pause edge number half+3-GUARD. slip_pos is set after that edge. The bit read on that edge is the one with index W-half, where W is the number of bits written, so already-delivered data is read again.
- R6: slip_pos and slip_neg stay set until clr_flags is high on an edge. A slip on the same edge as clr_flags leaves its flag set.
- R7: centre_req high on an edge moves the read point to half the depth behind the synchronised write pointer. The read on that same edge follows R3, and no flag is raised.
- R8: A change of size_code re-centres on the edge where the new code is first seen. The read on that edge already follows R3 with the new half depth.
- R9: While rd_en is low, rd_bit holds its value.
- R10: Skip and replay slips work, with the timing of R4 and R5, at all four size codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain reset, active low |
| wr_en | input | 1 | Store wr_bit on this write edge |
| wr_bit | input | 1 | Serial data in |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain reset, active low |
| rd_en | input | 1 | Read one bit on this read edge |
| size_code | input | 2 | Active depth select (see R1) |
| centre_req | input | 1 | Re-centre the delay on this edge |
| clr_flags | input | 1 | Clear both slip flags on this edge |
| rd_bit | output | 1 | Serial data out, registered |
| slip_pos | output | 1 | Sticky replay-slip flag |
| slip_neg | output | 1 | Sticky skip-slip flag |

## Verification
Both domains run from one bench clock, so every result can be placed on an exact edge. rd_bit and the flags are registered outputs. They change on the edge that performs the read or the slip, and the bench samples them at the following falling edge. The synchronised write pointer lags by two edges, and the expected bit index carries that lag, together with the bench's own count of written bits and the half depth. Slip edges are found by counting pause edges from a centred state and comparing the count with half-GUARD+1 or half+3-GUARD.

// File: rtl/esb_pkg.sv
package esb_pkg;

   localparam int SIZE_W = 2;

   typedef logic [SIZE_W-1:0] size_code_t;

   typedef enum logic [SIZE_W-1:0] {
      SZ_FULL    = 2'b00,
      SZ_HALF    = 2'b01,
      SZ_QUARTER = 2'b10,
      SZ_EIGHTH  = 2'b11
   } size_sel_e;

   // Active depth for a size code: each step halves the store.
   function automatic int depth_for(input int max_depth, input size_code_t code);
      return max_depth >> code;
   endfunction

endpackage

// File: rtl/esb_wr_store.sv
module esb_wr_store #(
   parameter int DEPTH = 256,
   localparam int PW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_bit,
   output logic [DEPTH-1:0] store,
   output logic [PW-1:0]    wgray
);

   logic [PW-1:0] wptr;
   logic [PW-1:0] wptr_nx;

   always_comb wptr_nx = wptr + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         wgray <= '0;
         store <= '0;
      end else if (wr_en) begin
         store[wptr] <= wr_bit;
         wptr        <= wptr_nx;
         wgray       <= wptr_nx ^ (wptr_nx >> 1);
      end
   end

   // R3: the crossing pointer changes at most one bit per write edge
   gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   // R3: an idle write edge leaves the published pointer alone
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wgray));

endmodule

// File: rtl/esb_ptr_sync.sv
module esb_ptr_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= gray_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
      logic [W-1:0] b;
      b[W-1] = g[W-1];
      for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   always_comb bin_out = gray_to_bin(stg[STAGES-1]);

endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl
   import esb_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int GUARD = 2,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = PW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  size_code_t       size_code,
   input  logic             centre_req,
   input  logic             clr_flags,
   input  logic [PW-1:0]    wsync,
   input  logic [DEPTH-1:0] store,
   output logic             rd_bit,
   output logic             slip_pos,
   output logic             slip_neg
);

   logic [PW-1:0] rptr;
   logic [PW-1:0] fill;
   logic [PW-1:0] base;
   logic [CW-1:0] depth_cur;
   logic [CW-1:0] half_cur;
   logic [CW-1:0] fill_w;
   size_code_t    size_q;
   logic          pend;
   logic          recentre;
   logic          pos_hit;
   logic          neg_hit;

   always_comb begin
      depth_cur = CW'(depth_for(DEPTH, size_code));
      half_cur  = depth_cur >> 1;
      fill      = (wsync - rptr) & PW'(depth_cur - CW'(1));
      fill_w    = {1'b0, fill};
      recentre  = pend | centre_req | (size_code != size_q);
      neg_hit   = !recentre && (fill_w >= depth_cur - CW'(GUARD));
      pos_hit   = !recentre && (fill_w <= CW'(GUARD));
      base      = (recentre | neg_hit | pos_hit) ? (wsync - PW'(half_cur)) : rptr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr     <= '0;
         size_q   <= SZ_FULL;
         pend     <= 1'b1;
         rd_bit   <= 1'b0;
         slip_pos <= 1'b0;
         slip_neg <= 1'b0;
      end else begin
         pend   <= 1'b0;
         size_q <= size_code;
         if (rd_en) begin
            rd_bit <= store[base];
            rptr   <= base + PW'(1);
         end else begin
            rptr   <= base;
         end
         slip_pos <= pos_hit | (slip_pos & ~clr_flags);
         slip_neg <= neg_hit | (slip_neg & ~clr_flags);
      end
   end

   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_bit));

   // R6
   pos_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_pos && !clr_flags |=> slip_pos);

   // R6
   neg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slip_neg && !clr_flags |=> slip_neg);

   // R7
   centre_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      centre_req && !slip_pos && !slip_neg |=> !slip_pos && !slip_neg);

   // R4
   slip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slip_pos && !slip_neg |=> !(slip_pos && slip_neg));

endmodule

// File: rtl/slip_elastic_store.sv
module slip_elastic_store
   import esb_pkg::*;
#(
   parameter int MAX_DEPTH   = 256,
   parameter int GUARD       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int PW = $clog2(MAX_DEPTH)
) (
   input  logic       wr_clk,
   input  logic       wr_rst_n,
   input  logic       wr_en,
   input  logic       wr_bit,
   input  logic       rd_clk,
   input  logic       rd_rst_n,
   input  logic       rd_en,
   input  logic [1:0] size_code,
   input  logic       centre_req,
   input  logic       clr_flags,
   output logic       rd_bit,
   output logic       slip_pos,
   output logic       slip_neg
);

   localparam int MIN_DEPTH = MAX_DEPTH >> 3;

   if (MAX_DEPTH != (1 << PW)) begin : g_bad_depth
      $error("MAX_DEPTH must be a power of two");
   end
   if (MIN_DEPTH <= 4 * GUARD + 2 * SYNC_STAGES) begin : g_bad_guard
      $error("GUARD too large for the smallest size setting");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [MAX_DEPTH-1:0] store;
   logic [PW-1:0]        wgray;
   logic [PW-1:0]        wsync;

   esb_wr_store #(.DEPTH(MAX_DEPTH)) u_wr (
      .clk   (wr_clk),
      .rst_n (wr_rst_n),
      .wr_en (wr_en),
      .wr_bit(wr_bit),
      .store (store),
      .wgray (wgray)
   );

   esb_ptr_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (rd_clk),
      .rst_n  (rd_rst_n),
      .gray_in(wgray),
      .bin_out(wsync)
   );

   esb_rd_ctrl #(.DEPTH(MAX_DEPTH), .GUARD(GUARD)) u_rd (
      .clk       (rd_clk),
      .rst_n     (rd_rst_n),
      .rd_en     (rd_en),
      .size_code (size_code_t'(size_code)),
      .centre_req(centre_req),
      .clr_flags (clr_flags),
      .wsync     (wsync),
      .store     (store),
      .rd_bit    (rd_bit),
      .slip_pos  (slip_pos),
      .slip_neg  (slip_neg)
   );

endmodule

// File: tb/sim_slip_elastic_store.sv
module sim_slip_elastic_store;

   localparam int CLK_PERIOD = 10;
   localparam int GRD = 2;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_bit = 1'b0;
   logic rd_en = 1'b0;
   logic [1:0] size_code = 2'b00;
   logic centre_req = 1'b0;
   logic clr_flags = 1'b0;
   logic rd_bit;
   logic slip_pos;
   logic slip_neg;

   int checks = 0;
   int fails = 0;
   int wc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slip_elastic_store u0 (
      .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
      .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en),
      .size_code(size_code), .centre_req(centre_req), .clr_flags(clr_flags),
      .rd_bit(rd_bit), .slip_pos(slip_pos), .slip_neg(slip_neg)
   );

   function automatic logic pat(input int n);
      logic [31:0] h;
      h = 32'(n) * 32'h9E3779B1;
      return h[27] ^ h[14];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      if (wr_en) wc++;
      @(negedge clk);
      wr_bit = pat(wc);
   endtask

   task automatic run_both(input int half, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         wr_en = 1'b1; rd_en = 1'b1;
         step();
         chk(rd_bit == pat(wc - LAT - half), tag, rd_bit, pat(wc - LAT - half));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++; checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int half;
      int cnt;
      int ws;
      int exp_cnt;
      logic held;
      repeat (3) @(negedge clk);
      // R2 reset state
      chk(rd_bit == 1'b0, "R2 rd_bit in reset", rd_bit, 0);
      chk(slip_pos == 1'b0 && slip_neg == 1'b0, "R2 flags in reset", {slip_pos, slip_neg}, 0);
      rst_n = 1'b1;
      wr_bit = pat(wc);
      step();
      chk(slip_pos == 1'b0 && slip_neg == 1'b0, "R2 no flag on first centring", {slip_pos, slip_neg}, 0);
      wr_en = 1'b1; rd_en = 1'b1;
      repeat (300) step();
      clr_flags = 1'b1; step(); clr_flags = 1'b0;
      // R7 centring at full depth, R3 steady delay
      centre_req = 1'b1;
      run_both(128, 1, "R7 centre edge");
      centre_req = 1'b0;
      chk(slip_pos == 1'b0 && slip_neg == 1'b0, "R7 centre raises no flag", {slip_pos, slip_neg}, 0);
      run_both(128, 16, "R3 steady delay");

      for (int idx = 0; idx < 4; idx++) begin
         logic [1:0] c;
         c = 2'((idx + 1) % 4);
         half = (256 >> c) / 2;
         // R8 size change re-centres; R1 depth per code
         size_code = c;
         run_both(half, 8, "R8 R1 size change centring");
         chk(slip_pos == 1'b0 && slip_neg == 1'b0, "R8 no flag on size change", {slip_pos, slip_neg}, 0);

         // R4 / R10 skip slip with reads paused
         exp_cnt = half - GRD + 1;
         cnt = 0;
         while (!slip_neg && cnt < 600) begin
            held = rd_bit;
            wr_en = 1'b1; rd_en = 1'b0;
            clr_flags = (idx == 1 && cnt + 1 == exp_cnt);
            step();
            cnt++;
            chk(rd_bit == held, "R9 rd_bit held while idle", rd_bit, held);
         end
         clr_flags = 1'b0;
         chk(cnt == exp_cnt, "R4 R10 R1 skip slip edge", cnt, exp_cnt);
         chk(slip_pos == 1'b0, "R4 no replay flag on skip", slip_pos, 0);
         if (idx == 1) chk(slip_neg == 1'b1, "R6 set wins over clear", slip_neg, 1);
         ws = wc;
         for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; rd_en = 1'b1;
            step();
            chk(rd_bit == pat(ws - LAT - half + i), "R4 data skipped", rd_bit, pat(ws - LAT - half + i));
         end
         chk(slip_neg == 1'b1, "R6 skip flag sticky", slip_neg, 1);
         clr_flags = 1'b1; step(); clr_flags = 1'b0;
         chk(slip_pos == 1'b0 && slip_neg == 1'b0, "R6 clear", {slip_pos, slip_neg}, 0);

         // R7 centre again, then R5 / R10 replay slip with writes paused
         centre_req = 1'b1;
         run_both(half, 1, "R7 centre edge");
         centre_req = 1'b0;
         run_both(half, 4, "R7 R3 delay after centre");
         exp_cnt = half + 3 - GRD;
         cnt = 0;
         while (!slip_pos && cnt < 600) begin
            wr_en = 1'b0; rd_en = 1'b1;
            step();
            cnt++;
         end
         chk(cnt == exp_cnt, "R5 R10 R1 replay slip edge", cnt, exp_cnt);
         chk(slip_neg == 1'b0, "R5 no skip flag on replay", slip_neg, 0);
         ws = wc;
         chk(rd_bit == pat(ws - half), "R5 replayed bit", rd_bit, pat(ws - half));
         for (int i = 1; i < 8; i++) begin
            wr_en = 1'b0; rd_en = 1'b1;
            step();
            chk(rd_bit == pat(ws - half + i), "R5 replay run", rd_bit, pat(ws - half + i));
         end
         chk(slip_pos == 1'b1, "R6 replay flag sticky", slip_pos, 1);
         wr_en = 1'b1; rd_en = 1'b1;
         repeat (4) step();
         clr_flags = 1'b1; step(); clr_flags = 1'b0;
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule